// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block drives one transmit gate enable per traffic class from a cyclic schedule of gate operations. Each operation in the schedule pairs a gate vector with a duration in nanoseconds. In the vector, bit i belongs to class i, and 1 means open. The block watches a synchronized time of day, given as seconds plus nanoseconds, and compares it against a programmed base time. When that time is reached, the block applies the first operation. It then steps through the active operations in index order and starts the schedule again from operation 0 at every cycle boundary. Any mix of open and closed bits is legal in an operation, and no class gets special treatment.

Software programs the schedule while the block is disabled. Setting the enable input captures the base time, the cycle length, the index of the last active operation and an initial gate vector, and the block then waits for the base time. The schedule has a fixed length in time. If the operations add up to more than that length, the running operation is cut off at the boundary. If they add up to less, the last operation stays in force until the boundary.

Top module: `gate_cycle_sched`

## Requirements
- R1: After reset, `gate_o` is all ones (every class open).
- R2: While `sched_en` is low, `gate_o` is all ones one clock later.
- R3: On the clock where `sched_en` is first seen high, the block captures `cfg_init_gates`, `cfg_base_sec`/`cfg_base_ns`, `cfg_cycle_ns` and `cfg_last_idx`. `gate_o` then shows the captured initial vector until the time input reaches the base time.
- R4: On the first clock where (`tod_sec`,`tod_ns`) is at or past the base time, the gate vector of entry 0 appears on `gate_o` after that clock edge.
- R5: Entries run in ascending index order. Entry k stays in force for its interval. When the time input reaches the end of entry k, the gate vector of entry k+1 appears on `gate_o` within one clock.
- R6: Once entry `cfg_last_idx` is running, its vector is held until the cycle boundary. Entries with a higher index never appear on `gate_o`.
- R7: Each time the time input reaches the cycle boundary (base plus n times the cycle length), entry 0 restarts within one clock. This holds even when the running entry's interval has not yet expired.
- R8: Every computed time (entry ends, cycle ends) carries from nanoseconds into seconds at 1,000,000,000 ns.
- R9: An entry write (`cfg_we` with `cfg_idx`, `cfg_gates`, `cfg_interval`) is stored only while `sched_en` is low. A write made while it is high has no effect on the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_en | input | 1 | Scheduler enable; rising level arms the base-time wait |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | 4 | Entry index written |
| cfg_gates | input | 8 | Gate vector of the written entry (bit i = class i, 1 = open) |
| cfg_interval | input | 32 | Duration of the written entry in ns |
| cfg_last_idx | input | 4 | Index of the last active entry |
| cfg_cycle_ns | input | 32 | Cycle length in ns |
| cfg_base_sec | input | 32 | Base time, seconds part |
| cfg_base_ns | input | 30 | Base time, nanoseconds part (below 10^9) |
| cfg_init_gates | input | 8 | Gate vector shown while waiting for the base time |
| tod_sec | input | 32 | Synchronized time, seconds |
| tod_ns | input | 30 | Synchronized time, nanoseconds (below 10^9) |
| gate_o | output | 8 | Registered gate enables, one per class |

## Verification
The bench uses the default parameters: eight classes, sixteen entries, 32-bit intervals and 32-bit seconds. With these values a three-entry list can be run against two cycle lengths. A 500 ns cycle exercises the hold of the last entry. A 250 ns cycle cuts the second entry short. The second run places its base time 100 ns before a seconds rollover, so entry ends and cycle ends both carry into the next second.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  localparam int unsigned NS_PER_SEC = 1_000_000_000;
  localparam int NS_W = 30;

  typedef enum logic [1:0] {
    S_OFF   = 2'd0,
    S_ARMED = 2'd1,
    S_RUN   = 2'd2
  } sched_state_e;
endpackage

// File: rtl/gcs_list_mem.sv
module gcs_list_mem #(
  parameter int DEPTH  = 16,
  parameter int GATE_W = 8,
  parameter int IV_W   = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = GATE_W + IV_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [GATE_W-1:0] wgates,
  input  logic [IV_W-1:0]   wiv,
  input  logic [AW-1:0]     raddr,
  output logic [GATE_W-1:0] rgates,
  output logic [IV_W-1:0]   riv
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= {wgates, wiv};
  end

  assign {rgates, riv} = store[raddr];
endmodule

// File: rtl/gcs_time_add.sv
module gcs_time_add
  import gcs_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int IV_W  = 32,
  localparam int SUM_W = IV_W + 2,
  localparam int STEPS = int'(((64'd1 << IV_W) + 64'(NS_PER_SEC)) / 64'(NS_PER_SEC)) + 1
) (
  input  logic [SEC_W-1:0] a_sec,
  input  logic [NS_W-1:0]  a_ns,
  input  logic [IV_W-1:0]  delta,
  output logic [SEC_W-1:0] y_sec,
  output logic [NS_W-1:0]  y_ns
);
  logic [SUM_W-1:0] part [STEPS+1];
  logic [SEC_W-1:0] carry [STEPS+1];

  assign part[0]  = SUM_W'(a_ns) + SUM_W'(delta);
  assign carry[0] = '0;

  for (genvar k = 0; k < STEPS; k++) begin : g_wrap
    always_comb begin
      if (part[k] >= SUM_W'(NS_PER_SEC)) begin
        part[k+1]  = part[k] - SUM_W'(NS_PER_SEC);
        carry[k+1] = carry[k] + SEC_W'(1);
      end else begin
        part[k+1]  = part[k];
        carry[k+1] = carry[k];
      end
    end
  end

  assign y_sec = a_sec + carry[STEPS];
  assign y_ns  = part[STEPS][NS_W-1:0];
endmodule

// File: rtl/gcs_time_cmp.sv
module gcs_time_cmp
  import gcs_pkg::*;
#(
  parameter int SEC_W = 32
) (
  input  logic [SEC_W-1:0] now_sec,
  input  logic [NS_W-1:0]  now_ns,
  input  logic [SEC_W-1:0] ref_sec,
  input  logic [NS_W-1:0]  ref_ns,
  output logic             reached
);
  assign reached = (now_sec > ref_sec) || ((now_sec == ref_sec) && (now_ns >= ref_ns));
endmodule

// File: rtl/gate_cycle_sched.sv
module gate_cycle_sched
  import gcs_pkg::*;
#(
  parameter int NCLS    = 8,
  parameter int ENTRIES = 16,
  parameter int IV_W    = 32,
  parameter int SEC_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sched_en,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [NCLS-1:0]  cfg_gates,
  input  logic [IV_W-1:0]  cfg_interval,
  input  logic [IDX_W-1:0] cfg_last_idx,
  input  logic [IV_W-1:0]  cfg_cycle_ns,
  input  logic [SEC_W-1:0] cfg_base_sec,
  input  logic [NS_W-1:0]  cfg_base_ns,
  input  logic [NCLS-1:0]  cfg_init_gates,
  input  logic [SEC_W-1:0] tod_sec,
  input  logic [NS_W-1:0]  tod_ns,
  output logic [NCLS-1:0]  gate_o
);
  sched_state_e     state_q;
  logic [IDX_W-1:0] idx_q, last_q, rd_idx;
  logic [IV_W-1:0]  cycle_q;
  logic [SEC_W-1:0] base_sec_q, ent_sec_q, cyc_sec_q;
  logic [NS_W-1:0]  base_ns_q, ent_ns_q, cyc_ns_q;
  logic [NCLS-1:0]  init_q, gate_q, rd_gates;
  logic [IV_W-1:0]  rd_iv;
  logic             hit_base, hit_ent, hit_cyc;
  logic             start, restart, advance;
  logic [SEC_W-1:0] ent_op_sec, cyc_op_sec, ent_nx_sec, cyc_nx_sec;
  logic [NS_W-1:0]  ent_op_ns, cyc_op_ns, ent_nx_ns, cyc_nx_ns;

  gcs_list_mem #(.DEPTH(ENTRIES), .GATE_W(NCLS), .IV_W(IV_W)) u_mem (
    .clk(clk), .we(cfg_we && !sched_en && state_q == S_OFF),
    .waddr(cfg_idx), .wgates(cfg_gates), .wiv(cfg_interval),
    .raddr(rd_idx), .rgates(rd_gates), .riv(rd_iv)
  );

  gcs_time_cmp #(.SEC_W(SEC_W)) u_cmp_base (
    .now_sec(tod_sec), .now_ns(tod_ns), .ref_sec(base_sec_q), .ref_ns(base_ns_q),
    .reached(hit_base));
  gcs_time_cmp #(.SEC_W(SEC_W)) u_cmp_ent (
    .now_sec(tod_sec), .now_ns(tod_ns), .ref_sec(ent_sec_q), .ref_ns(ent_ns_q),
    .reached(hit_ent));
  gcs_time_cmp #(.SEC_W(SEC_W)) u_cmp_cyc (
    .now_sec(tod_sec), .now_ns(tod_ns), .ref_sec(cyc_sec_q), .ref_ns(cyc_ns_q),
    .reached(hit_cyc));

  assign start   = (state_q == S_ARMED) && hit_base;
  assign restart = (state_q == S_RUN) && hit_cyc;
  assign advance = (state_q == S_RUN) && !hit_cyc && hit_ent && (idx_q != last_q);
  assign rd_idx  = (start || restart) ? '0 : idx_q + IDX_W'(1);

  always_comb begin
    if (start) begin
      ent_op_sec = base_sec_q; ent_op_ns = base_ns_q;
    end else if (restart) begin
      ent_op_sec = cyc_sec_q;  ent_op_ns = cyc_ns_q;
    end else begin
      ent_op_sec = ent_sec_q;  ent_op_ns = ent_ns_q;
    end
    cyc_op_sec = start ? base_sec_q : cyc_sec_q;
    cyc_op_ns  = start ? base_ns_q  : cyc_ns_q;
  end

  gcs_time_add #(.SEC_W(SEC_W), .IV_W(IV_W)) u_add_ent (
    .a_sec(ent_op_sec), .a_ns(ent_op_ns), .delta(rd_iv),
    .y_sec(ent_nx_sec), .y_ns(ent_nx_ns));
  gcs_time_add #(.SEC_W(SEC_W), .IV_W(IV_W)) u_add_cyc (
    .a_sec(cyc_op_sec), .a_ns(cyc_op_ns), .delta(cycle_q),
    .y_sec(cyc_nx_sec), .y_ns(cyc_nx_ns));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_OFF;
      gate_q  <= '1;
      idx_q   <= '0;
      last_q  <= '0;
      cycle_q <= '0;
      init_q  <= '1;
      base_sec_q <= '0; base_ns_q <= '0;
      ent_sec_q  <= '0; ent_ns_q  <= '0;
      cyc_sec_q  <= '0; cyc_ns_q  <= '0;
    end else if (!sched_en) begin
      state_q <= S_OFF;
      gate_q  <= '1;
    end else begin
      unique case (state_q)
        S_OFF: begin
          state_q    <= S_ARMED;
          init_q     <= cfg_init_gates;
          gate_q     <= cfg_init_gates;
          last_q     <= cfg_last_idx;
          cycle_q    <= cfg_cycle_ns;
          base_sec_q <= cfg_base_sec;
          base_ns_q  <= cfg_base_ns;
        end
        S_ARMED: begin
          if (start) begin
            state_q   <= S_RUN;
            idx_q     <= '0;
            gate_q    <= rd_gates;
            ent_sec_q <= ent_nx_sec; ent_ns_q <= ent_nx_ns;
            cyc_sec_q <= cyc_nx_sec; cyc_ns_q <= cyc_nx_ns;
          end
        end
        default: begin
          if (restart) begin
            idx_q     <= '0;
            gate_q    <= rd_gates;
            ent_sec_q <= ent_nx_sec; ent_ns_q <= ent_nx_ns;
            cyc_sec_q <= cyc_nx_sec; cyc_ns_q <= cyc_nx_ns;
          end else if (advance) begin
            idx_q     <= rd_idx;
            gate_q    <= rd_gates;
            ent_sec_q <= ent_nx_sec; ent_ns_q <= ent_nx_ns;
          end
        end
      endcase
    end
  end

  assign gate_o = gate_q;

  // R2
  off_open_chk: assert property (@(posedge clk) disable iff (rst)
    !sched_en |=> gate_o == '1);

  // R3
  armed_init_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ARMED) |-> gate_o == init_q);

  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RUN) |-> idx_q <= last_q);

  // R6
  hold_last_chk: assert property (@(posedge clk) disable iff (rst)
    (sched_en && state_q == S_RUN && idx_q == last_q && !hit_cyc) |=> $stable(gate_o));

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sched_en && restart) |=> idx_q == '0);
endmodule

// File: tb/test_gate_cycle_sched.sv
module test_gate_cycle_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sched_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [7:0]  cfg_gates = '0;
  logic [31:0] cfg_interval = '0;
  logic [3:0]  cfg_last_idx = '0;
  logic [31:0] cfg_cycle_ns = '0;
  logic [31:0] cfg_base_sec = '0;
  logic [29:0] cfg_base_ns = '0;
  logic [7:0]  cfg_init_gates = '0;
  logic [31:0] tod_sec = '0;
  logic [29:0] tod_ns = '0;
  logic [7:0]  gate_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gate_cycle_sched i_gate_cycle_sched (
    .clk(clk), .rst(rst), .sched_en(sched_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_gates(cfg_gates), .cfg_interval(cfg_interval), .cfg_last_idx(cfg_last_idx),
    .cfg_cycle_ns(cfg_cycle_ns), .cfg_base_sec(cfg_base_sec), .cfg_base_ns(cfg_base_ns),
    .cfg_init_gates(cfg_init_gates), .tod_sec(tod_sec), .tod_ns(tod_ns), .gate_o(gate_o)
  );

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (gate_o !== exp) begin
      errors++;
      $display("FAIL %s: gate_o=%h expected=%h", req, gate_o, exp);
    end
  endtask

  task automatic step(input logic [31:0] s, input logic [29:0] n,
                      input logic [7:0] exp, input string req);
    tod_sec = s;
    tod_ns  = n;
    @(posedge clk);
    @(negedge clk);
    check(req, exp);
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] g, input logic [31:0] iv);
    cfg_we = 1'b1; cfg_idx = i; cfg_gates = g; cfg_interval = iv;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // {sec, ns, expected gates}; run with base (5,0), cycle 500, entries 100/200/50
  localparam int NV = 11;
  localparam logic [69:0] RUN1 [NV] = '{
    {32'd4, 30'd999_999_990, 8'h0F},  // R3 waiting
    {32'd5, 30'd0,           8'h81},  // R4 start
    {32'd5, 30'd50,          8'h81},  // R5 within entry 0
    {32'd5, 30'd100,         8'h42},  // R5 entry 1
    {32'd5, 30'd299,         8'h42},  // R5
    {32'd5, 30'd300,         8'h3C},  // R5 entry 2
    {32'd5, 30'd400,         8'h3C},  // R6 hold last, entry 3 never shown
    {32'd5, 30'd499,         8'h3C},  // R6
    {32'd5, 30'd500,         8'h81},  // R7 restart
    {32'd5, 30'd600,         8'h42},  // R5 second cycle
    {32'd5, 30'd1000,        8'h81}   // R7
  };

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", 8'hFF);

    wr(4'd0, 8'h81, 32'd100);
    wr(4'd1, 8'h42, 32'd200);
    wr(4'd2, 8'h3C, 32'd50);
    wr(4'd3, 8'h00, 32'd10);
    check("R2", 8'hFF);

    cfg_last_idx = 4'd2; cfg_cycle_ns = 32'd500;
    cfg_base_sec = 32'd5; cfg_base_ns = 30'd0; cfg_init_gates = 8'h0F;
    tod_sec = 32'd4; tod_ns = 30'd0;
    sched_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R3", 8'h0F);

    for (int v = 0; v < NV; v++) begin
      step(RUN1[v][69:38], RUN1[v][37:8], RUN1[v][7:0], "R5/R6/R7 table");
    end

    // R2: disable opens every gate
    sched_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2", 8'hFF);

    // R7 R8: cycle 250 shorter than entry sum, base before a second rollover
    cfg_cycle_ns = 32'd250; cfg_base_sec = 32'd6; cfg_base_ns = 30'd999_999_900;
    cfg_init_gates = 8'hA5;
    tod_sec = 32'd6; tod_ns = 30'd0;
    sched_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R3", 8'hA5);
    step(32'd6, 30'd999_999_899, 8'hA5, "R3");
    step(32'd6, 30'd999_999_900, 8'h81, "R4");
    step(32'd6, 30'd999_999_999, 8'h81, "R8");
    step(32'd7, 30'd0,           8'h42, "R8");
    // R9: write while enabled must be ignored
    wr(4'd0, 8'h00, 32'd5);
    step(32'd7, 30'd149,         8'h42, "R7");
    step(32'd7, 30'd150,         8'h81, "R7 R9");
    step(32'd7, 30'd250,         8'h42, "R7");
    step(32'd7, 30'd400,         8'h81, "R7 R9");
    step(32'd7, 30'd449,         8'h81, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule